// File: doc/BRIEF.md
# Reset Time-out Sequencer

This block decides when the on-chip reset is released after power is applied, after a supply sag, and after a wake from a low-power sleep. A power-on pulse starts a chain of waits. The first wait is a supply settling delay counted on a slow internal RC tick. The second is an oscillator settling count on the main clock, used only in the crystal modes. The third is a lock wait for the frequency multiplier, also counted on the RC tick, used only when the multiplier is enabled. Each wait can be dropped by configuration, and the next one starts only when the one before it has finished.

A supply-low flag from an analog comparator goes through a digital glitch filter. A sag that lasts longer than the filter window holds the chip in reset until the flag clears. The settling delay then runs again, and a fresh sag during that delay starts it over from zero. The active-low master clear pin is synchronised into the clock domain. It holds reset while low but does not restart any timer, so raising it after the waits have expired releases the chip almost at once. Three sticky flags record which reset sources have fired since the last power-on.

Top module: `rst_timeout_seq`

## Requirements
- R1: While `por_pulse` is high, `rst_hold` is 1, `cause_por` is 1, and `cause_bor` and `cause_mclr` are 0.
- R2: With `cfg_pwrt_en` = 1, a power-on first waits for `PWRT_TICKS` clock edges that sample `rc_tick` high. The first edge after `por_pulse` falls only selects the first stage and counts no tick.
- R3: `cfg_osc_mode` encodes 0 = LP, 1 = XT, 2 = HS and 3 = RC. The first three are crystal modes. In a crystal mode, after power-on the block counts `OST_CYCLES` (default 1024) clock edges once the settling delay is done, or from the stage-select edge when that delay is disabled.
- R4: In RC mode (3) the oscillator count is skipped entirely.
- R5: With `cfg_pll_en` = 1, a power-on sequence ends with a lock wait of `PLL_TICKS` sampled `rc_tick` pulses before release.
- R6: In RC mode with the settling delay and multiplier disabled and `mclr_n` high, `rst_hold` falls at the second clock edge after `por_pulse` falls.
- R7: With `cfg_bor_en` = 1, `bor_low` trips a brown-out reset only when it is sampled high on `BOR_FILT`+1 consecutive edges. Shorter pulses leave `rst_hold` and `cause_bor` unchanged. With `cfg_bor_en` = 0, `bor_low` is ignored.
- R8: In brown-out reset, `rst_hold` stays 1 while `bor_low` is high. When it clears, the settling delay runs again from zero if enabled, and then reset releases with no oscillator or lock wait. A new trip during that delay returns to brown-out reset and restarts the delay.
- R9: `mclr_n` passes through a two-flop synchroniser. It changes `rst_hold` at the second edge after it changes, holds reset while low, and never restarts a timer. If the waits expired while it was low, reset releases two edges after it rises.
- R10: `cause_bor` sets on entry to brown-out reset. `cause_mclr` sets when the synchronised `mclr_n` falls from high. Both flags, and `cause_por`, are cleared only by `por_pulse`.
- R11: A `wake_req` pulse while running reasserts `rst_hold` and reruns the oscillator count (then the lock wait if enabled) in a crystal mode. In RC mode it has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main oscillator clock, also the sequencer clock |
| por_pulse | input | 1 | Power-on pulse, active high, asynchronous |
| mclr_n | input | 1 | External master clear, active low, asynchronous |
| bor_low | input | 1 | Supply-low comparator flag, synchronous to clk |
| wake_req | input | 1 | One-cycle pulse on wake from sleep |
| rc_tick | input | 1 | One-cycle pulse from the internal RC time base |
| cfg_pwrt_en | input | 1 | Enable the supply settling delay |
| cfg_bor_en | input | 1 | Enable brown-out reset |
| cfg_osc_mode | input | 2 | Oscillator mode: 0 LP, 1 XT, 2 HS, 3 RC |
| cfg_pll_en | input | 1 | Enable the frequency multiplier lock wait |
| rst_hold | output | 1 | Internal reset, 1 = held |
| cause_por | output | 1 | Sticky flag: power-on reset seen |
| cause_bor | output | 1 | Sticky flag: brown-out reset seen |
| cause_mclr | output | 1 | Sticky flag: master clear reset seen |

## Verification
The in-line properties check on every cycle that the stage counter never passes the limit of its stage and that brown-out reset cannot be left while the supply flag is high. They also check that the filter never trips on a single sample, that brown-out reset is never entered while it is disabled, that master clear never moves the sequencer out of the running state, that the oscillator count is entered only from an allowed predecessor, and that no cause flag ever clears outside power-on. The exact release edge of each chain of waits can only be shown by the directed scenarios. These include the skipped stages, the restart of the settling delay after a second sag, the glitch that must be ignored, and the quick release after a long master clear.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;

  typedef enum logic [2:0] {
    ST_INIT = 3'd0,
    ST_PWRT = 3'd1,
    ST_OST  = 3'd2,
    ST_PLL  = 3'd3,
    ST_RUN  = 3'd4,
    ST_BOR  = 3'd5
  } seq_st_e;

  localparam logic [1:0] OSC_RC = 2'd3;

  // Crystal modes need the oscillator settling count.
  function automatic logic is_xtal(input logic [1:0] mode);
    return mode != OSC_RC;
  endfunction

  function automatic seq_st_e after_ost(input logic pll_en);
    return pll_en ? ST_PLL : ST_RUN;
  endfunction

  function automatic seq_st_e after_pwrt(input logic [1:0] mode, input logic pll_en);
    return is_xtal(mode) ? ST_OST : after_ost(pll_en);
  endfunction

  function automatic seq_st_e first_stage(input logic pwrt_en, input logic [1:0] mode,
                                          input logic pll_en);
    return pwrt_en ? ST_PWRT : after_pwrt(mode, pll_en);
  endfunction

  // Stages paced by the slow RC time base.
  function automatic logic paced_by_rc(input seq_st_e st);
    return (st == ST_PWRT) || (st == ST_PLL);
  endfunction

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  // Counter width able to hold (n - 1), at least one bit.
  function automatic int last_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/rst_sync2.sv
module rst_sync2 (
  input  logic clk,
  input  logic arst,
  input  logic d,
  output logic q,
  output logic fall_next
);
  logic s1, s2;

  always_ff @(posedge clk or posedge arst) begin
    if (arst) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
    end else begin
      s1 <= d;
      s2 <= s1;
    end
  end

  assign q         = s2;
  // The synchronised level drops at the coming edge.
  assign fall_next = s2 & ~s1;
endmodule

// File: rtl/rst_glitch_filter.sv
module rst_glitch_filter #(
  parameter int FILT = 3
) (
  input  logic clk,
  input  logic arst,
  input  logic en,
  input  logic raw,
  output logic trip
);
  localparam int FW = $clog2(FILT + 1);
  localparam logic [FW-1:0] FULL = FW'(FILT);

  logic [FW-1:0] run_len;

  always_ff @(posedge clk or posedge arst) begin
    if (arst) begin
      run_len <= '0;
    end else if (!(en && raw)) begin
      run_len <= '0;
    end else if (run_len != FULL) begin
      run_len <= run_len + FW'(1);
    end
  end

  assign trip = en && raw && (run_len == FULL);

  AST_FLT_NEEDS_RUN: assert property (@(posedge clk) disable iff (arst)
    trip |-> $past(raw)); // R7
endmodule

// File: rtl/rst_stage_timer.sv
module rst_stage_timer #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         arst,
  input  logic         clr,
  input  logic         inc,
  input  logic [W-1:0] last,
  output logic         done
);
  logic [W-1:0] cnt;

  assign done = inc && (cnt == last);

  always_ff @(posedge clk or posedge arst) begin
    if (arst) begin
      cnt <= '0;
    end else if (clr || done) begin
      cnt <= '0;
    end else if (inc) begin
      cnt <= cnt + W'(1);
    end
  end

  AST_TMR_BOUND: assert property (@(posedge clk) disable iff (arst)
    cnt <= last); // R2
endmodule

// File: rtl/rst_timeout_seq.sv
module rst_timeout_seq
  import rst_seq_pkg::*;
#(
  parameter int PWRT_TICKS = 8,
  parameter int OST_CYCLES = 1024,
  parameter int PLL_TICKS  = 6,
  parameter int BOR_FILT   = 3
) (
  input  logic       clk,
  input  logic       por_pulse,
  input  logic       mclr_n,
  input  logic       bor_low,
  input  logic       wake_req,
  input  logic       rc_tick,
  input  logic       cfg_pwrt_en,
  input  logic       cfg_bor_en,
  input  logic [1:0] cfg_osc_mode,
  input  logic       cfg_pll_en,
  output logic       rst_hold,
  output logic       cause_por,
  output logic       cause_bor,
  output logic       cause_mclr
);
  localparam int TMAX = max3(PWRT_TICKS, OST_CYCLES, PLL_TICKS);
  localparam int TW   = last_width(TMAX);

  // Named internal events
  logic          mclr_s;
  logic          mclr_fall;
  logic          bor_trip;
  logic          tmr_done;
  logic          tmr_inc;
  logic [TW-1:0] tmr_last;
  logic          st_change;
  logic          from_bor;
  seq_st_e       st_q, st_d;

  rst_sync2 u_mclr_sync (
    .clk       (clk),
    .arst      (por_pulse),
    .d         (mclr_n),
    .q         (mclr_s),
    .fall_next (mclr_fall)
  );

  rst_glitch_filter #(.FILT(BOR_FILT)) u_bor_filt (
    .clk  (clk),
    .arst (por_pulse),
    .en   (cfg_bor_en),
    .raw  (bor_low),
    .trip (bor_trip)
  );

  // Per-stage limit and pacing
  always_comb begin
    unique case (st_q)
      ST_PWRT: tmr_last = TW'(PWRT_TICKS - 1);
      ST_OST:  tmr_last = TW'(OST_CYCLES - 1);
      ST_PLL:  tmr_last = TW'(PLL_TICKS - 1);
      default: tmr_last = '0;
    endcase
    if (paced_by_rc(st_q))   tmr_inc = rc_tick;
    else if (st_q == ST_OST) tmr_inc = 1'b1;
    else                     tmr_inc = 1'b0;
  end

  rst_stage_timer #(.W(TW)) u_timer (
    .clk  (clk),
    .arst (por_pulse),
    .clr  (st_change),
    .inc  (tmr_inc),
    .last (tmr_last),
    .done (tmr_done)
  );

  // Stage sequencing; a filtered supply sag wins over everything.
  always_comb begin
    st_d = st_q;
    if (bor_trip) begin
      st_d = ST_BOR;
    end else begin
      unique case (st_q)
        ST_INIT: st_d = first_stage(cfg_pwrt_en, cfg_osc_mode, cfg_pll_en);
        ST_PWRT: if (tmr_done) st_d = from_bor ? ST_RUN : after_pwrt(cfg_osc_mode, cfg_pll_en);
        ST_OST:  if (tmr_done) st_d = after_ost(cfg_pll_en);
        ST_PLL:  if (tmr_done) st_d = ST_RUN;
        ST_RUN:  if (wake_req && is_xtal(cfg_osc_mode)) st_d = ST_OST;
        ST_BOR:  if (!bor_low) st_d = cfg_pwrt_en ? ST_PWRT : ST_RUN;
        default: st_d = ST_INIT;
      endcase
    end
  end

  assign st_change = (st_d != st_q);

  always_ff @(posedge clk or posedge por_pulse) begin
    if (por_pulse) begin
      st_q     <= ST_INIT;
      from_bor <= 1'b0;
    end else begin
      st_q <= st_d;
      if (st_d == ST_BOR) from_bor <= 1'b1;
    end
  end

  // Sticky reset-cause flags
  always_ff @(posedge clk or posedge por_pulse) begin
    if (por_pulse) begin
      cause_por  <= 1'b1;
      cause_bor  <= 1'b0;
      cause_mclr <= 1'b0;
    end else begin
      if (st_q != ST_BOR && st_d == ST_BOR) cause_bor <= 1'b1;
      if (mclr_fall)                        cause_mclr <= 1'b1;
    end
  end

  assign rst_hold = (st_q != ST_RUN) || !mclr_s;

  AST_BOR_STICKS: assert property (@(posedge clk) disable iff (por_pulse)
    (st_q == ST_BOR && bor_low) |=> (st_q == ST_BOR)); // R8
  AST_BOR_OFF: assert property (@(posedge clk) disable iff (por_pulse)
    (!cfg_bor_en && st_q != ST_BOR) |=> (st_q != ST_BOR)); // R7
  AST_MCLR_NO_RESTART: assert property (@(posedge clk) disable iff (por_pulse)
    (st_q == ST_RUN && !mclr_s && !wake_req && !bor_trip) |=> (st_q == ST_RUN)); // R9
  AST_OST_ENTRY: assert property (@(posedge clk) disable iff (por_pulse)
    (st_q == ST_OST && $past(st_q) != ST_OST) |->
      ($past(st_q) == ST_PWRT || $past(st_q) == ST_RUN || $past(st_q) == ST_INIT)); // R3
  AST_CAUSE_STICKY: assert property (@(posedge clk) disable iff (por_pulse)
    !$fell(cause_bor) && !$fell(cause_mclr) && !$fell(cause_por)); // R10
endmodule

// File: tb/rst_timeout_seq_test.sv
module rst_timeout_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int PWRT = 8;
  localparam int OST  = 1024;
  localparam int PLL  = 6;
  localparam int FILT = 3;

  logic       clk = 1'b0;
  logic       por_pulse = 1'b1;
  logic       mclr_n = 1'b1;
  logic       bor_low = 1'b0;
  logic       wake_req = 1'b0;
  logic       rc_tick = 1'b0;
  logic       cfg_pwrt_en = 1'b1;
  logic       cfg_bor_en = 1'b0;
  logic [1:0] cfg_osc_mode = 2'd3;
  logic       cfg_pll_en = 1'b0;
  logic       rst_hold, cause_por, cause_bor, cause_mclr;

  int n_chk = 0;
  int n_fail = 0;

  rst_timeout_seq #(.PWRT_TICKS(PWRT), .OST_CYCLES(OST), .PLL_TICKS(PLL), .BOR_FILT(FILT)) uut (
    .clk(clk), .por_pulse(por_pulse), .mclr_n(mclr_n), .bor_low(bor_low),
    .wake_req(wake_req), .rc_tick(rc_tick), .cfg_pwrt_en(cfg_pwrt_en),
    .cfg_bor_en(cfg_bor_en), .cfg_osc_mode(cfg_osc_mode), .cfg_pll_en(cfg_pll_en),
    .rst_hold(rst_hold), .cause_por(cause_por), .cause_bor(cause_bor), .cause_mclr(cause_mclr)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step(input logic t);
    rc_tick = t;
    @(posedge clk);
    @(negedge clk);
    rc_tick = 1'b0;
  endtask

  task automatic steps(input int n);
    for (int i = 0; i < n; i++) step(1'b0);
  endtask

  task automatic tick_pairs(input int n);
    for (int i = 0; i < n; i++) begin
      step(1'b0);
      step(1'b1);
    end
  endtask

  task automatic do_por(input logic pwrt, input logic bor_en, input logic [1:0] mode, input logic pll);
    cfg_pwrt_en = pwrt; cfg_bor_en = bor_en; cfg_osc_mode = mode; cfg_pll_en = pll;
    bor_low = 1'b0; wake_req = 1'b0;
    por_pulse = 1'b1;
    steps(3);
    chk("R1", "hold in por", rst_hold, 1);
    chk("R1", "cause_por in por", cause_por, 1);
    chk("R1", "cause_bor in por", cause_bor, 0);
    chk("R1", "cause_mclr in por", cause_mclr, 0);
    por_pulse = 1'b0;
  endtask

  // XT, settling delay and lock wait all on; then wake from sleep.
  task automatic t_full_chain();
    do_por(1'b1, 1'b0, 2'd1, 1'b1);
    tick_pairs(PWRT - 1); step(1'b0);
    chk("R2", "held before last settle tick", rst_hold, 1);
    step(1'b1);
    chk("R3", "held entering osc count", rst_hold, 1);
    steps(OST - 1);
    chk("R3", "held before last osc cycle", rst_hold, 1);
    step(1'b0);
    chk("R5", "held entering lock wait", rst_hold, 1);
    tick_pairs(PLL - 1); step(1'b0);
    chk("R5", "held before last lock tick", rst_hold, 1);
    step(1'b1);
    chk("R5", "released after lock wait", rst_hold, 0);
    wake_req = 1'b1; step(1'b0); wake_req = 1'b0;
    chk("R11", "wake reasserts hold", rst_hold, 1);
    steps(OST - 1);
    chk("R11", "held during wake osc count", rst_hold, 1);
    step(1'b0);
    tick_pairs(PLL - 1); step(1'b0);
    chk("R11", "held in wake lock wait", rst_hold, 1);
    step(1'b1);
    chk("R11", "released after wake", rst_hold, 0);
    chk("R10", "cause_por kept", cause_por, 1);
    chk("R10", "cause_bor clear", cause_bor, 0);
  endtask

  // RC with settling delay: oscillator count skipped; wake ignored.
  task automatic t_rc_pwrt();
    do_por(1'b1, 1'b0, 2'd3, 1'b0);
    tick_pairs(PWRT - 1); step(1'b0);
    chk("R4", "held before last settle tick", rst_hold, 1);
    step(1'b1);
    chk("R4", "released without osc count", rst_hold, 0);
    wake_req = 1'b1; step(1'b0); wake_req = 1'b0;
    chk("R11", "wake ignored in RC", rst_hold, 0);
    steps(3);
    chk("R11", "still running after RC wake", rst_hold, 0);
  endtask

  task automatic t_rc_bare();
    do_por(1'b0, 1'b0, 2'd3, 1'b0);
    step(1'b0);
    chk("R6", "held one edge after por", rst_hold, 1);
    step(1'b0);
    chk("R6", "released two edges after por", rst_hold, 0);
  endtask

  task automatic t_hs_only();
    do_por(1'b0, 1'b0, 2'd2, 1'b0);
    steps(OST);
    chk("R3", "HS held before count ends", rst_hold, 1);
    step(1'b0);
    chk("R3", "HS released after count", rst_hold, 0);
  endtask

  task automatic t_pll_only();
    do_por(1'b0, 1'b0, 2'd3, 1'b1);
    step(1'b0);
    tick_pairs(PLL - 1); step(1'b0);
    chk("R5", "RC+PLL held before last tick", rst_hold, 1);
    step(1'b1);
    chk("R5", "RC+PLL released", rst_hold, 0);
  endtask

  task automatic t_mclr();
    mclr_n = 1'b0;
    do_por(1'b1, 1'b0, 2'd3, 1'b0);
    tick_pairs(PWRT + 4);
    chk("R9", "held while mclr low", rst_hold, 1);
    mclr_n = 1'b1;
    step(1'b0);
    chk("R9", "held one edge after mclr rise", rst_hold, 1);
    step(1'b0);
    chk("R9", "quick release after expiry", rst_hold, 0);
    mclr_n = 1'b0;
    step(1'b0);
    chk("R9", "sync delays mclr by two", rst_hold, 0);
    step(1'b0);
    chk("R9", "mclr low holds", rst_hold, 1);
    chk("R10", "cause_mclr set", cause_mclr, 1);
    mclr_n = 1'b1;
    steps(2);
    chk("R9", "no timer restart after mclr", rst_hold, 0);
    chk("R10", "cause_por kept after mclr", cause_por, 1);
  endtask

  task automatic t_bor();
    do_por(1'b1, 1'b1, 2'd1, 1'b0);
    tick_pairs(PWRT);
    steps(OST);
    chk("R3", "XT released after power-up", rst_hold, 0);
    bor_low = 1'b1; steps(FILT); bor_low = 1'b0;
    chk("R7", "short dip ignored", rst_hold, 0);
    step(1'b0);
    chk("R7", "short dip sets no flag", cause_bor, 0);
    bor_low = 1'b1; steps(FILT);
    chk("R7", "not tripped at filter length", rst_hold, 0);
    step(1'b0);
    chk("R7", "tripped past filter length", rst_hold, 1);
    chk("R10", "cause_bor set", cause_bor, 1);
    steps(5);
    chk("R8", "held while supply low", rst_hold, 1);
    bor_low = 1'b0; step(1'b0);
    tick_pairs(3);
    bor_low = 1'b1; steps(FILT + 1); bor_low = 1'b0;
    step(1'b0);
    tick_pairs(PWRT - 1); step(1'b0);
    chk("R8", "settle delay restarted", rst_hold, 1);
    step(1'b1);
    chk("R8", "released with no osc count", rst_hold, 0);
    cfg_bor_en = 1'b0;
    bor_low = 1'b1; steps(10);
    chk("R7", "disabled brown-out ignored", rst_hold, 0);
    bor_low = 1'b0;
  endtask

  initial begin
    @(negedge clk);
    t_full_chain();
    t_rc_pwrt();
    t_rc_bare();
    t_hs_only();
    t_pll_only();
    t_mclr();
    mclr_n = 1'b1;
    t_bor();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL R1 watchdog: got 0 expected 1 (run did not complete)");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule